// File: doc/BRIEF.md
# Serial FPGA configuration sequencer

This block loads a configuration image into a target FPGA that listens in slave-serial mode. A single start pulse powers the target, lets the supply settle, then holds the active-low program line low for a fixed time to clear the target. After release it polls the target's init-ready line, with a bounded number of polls. Once the target reports ready, the block pulls a given number of bytes from a valid/ready byte stream and shifts each one out on a data/clock pair. It then keeps clocking until the target raises its done line.

Every delay is derived from a parameter that gives clock cycles per millisecond. The half-period of the serial clock is a separate divider parameter. Two bounded waits can end a run in error: init never arriving, and done never arriving. Each has its own error kind. The byte source can also signal an error, which cuts the shift phase short and moves straight on to the done wait. Storing and parsing the image happen elsewhere. The block only sees a byte count and a byte stream.

Top module: `fpga_sercfg`

## Requirements
- R1: After reset `pwr_en`=0, `prog_n`=1, `cfg_clk`=0, `cfg_dat`=0, `src_ready`=0, `busy`=0, `ok`=0, `err`=0 and `err_kind`=0.
- R2: A start pulse taken while no run is in progress sets `pwr_en` and `busy` and clears `ok`, `err` and `err_kind`. `prog_n` then stays high for exactly SETTLE_MS*CYC_PER_MS cycles before it falls.
- R3: `prog_n` stays low for exactly PROG_MS*CYC_PER_MS cycles and then returns high. While it is low, `pwr_en` is high and `cfg_clk` and `cfg_dat` are low.
- R4: `tgt_init` is tested through a two-flop synchroniser. If it has not been seen high after INIT_TRIES polls following the release of `prog_n`, the run ends in error with `err_kind`=1 (init timeout), and no `cfg_clk` pulse is ever issued.
- R5: Exactly `byte_count` bytes (latched at start) are accepted on `src_valid`&&`src_ready` and shifted MSB first. For each bit `cfg_dat` is set while `cfg_clk` is low and held while it is high, and each high phase lasts CLK_DIV cycles. A count of zero accepts no byte.
- R6: When `src_fail` is high at the point where a byte would be requested, `src_ready` stays low, no further byte is accepted, and the run goes on to the done wait.
- R7: After the shift phase the block issues extra `cfg_clk` pulses with `cfg_dat` low until the synchronised `tgt_done` is high. If done is already high, no extra pulse is issued.
- R8: If done is not seen after DONE_PULSES extra pulses, the run ends in error with `err_kind`=2 (done timeout). No more than DONE_PULSES extra pulses are issued.
- R9: Success leaves `busy`=0 and `ok`=1. An error leaves both `busy` and `err` asserted. `ok` and `err` are never high together, and `err_kind` is non-zero exactly when `err` is high.
- R10: A start pulse during a run in progress is ignored: the program pulse is not repeated and the byte sequence is unchanged.
- R11: After a run has ended in error or success, a new start clears the previous outcome and begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a configuration run |
| byte_count | input | CNT_W | Number of image bytes to send, latched at start |
| src_data | input | 8 | Image byte offered by the source |
| src_valid | input | 1 | Source byte is valid |
| src_ready | output | 1 | Block accepts the offered byte this cycle |
| src_fail | input | 1 | Source reports an error; ends the shift phase early |
| tgt_init | input | 1 | Target init-ready line (high = ready) |
| tgt_done | input | 1 | Target configuration-done line |
| pwr_en | output | 1 | Target power enable |
| prog_n | output | 1 | Active-low program line to the target |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_dat | output | 1 | Serial configuration data |
| busy | output | 1 | Run in progress; left high after an error |
| ok | output | 1 | Last run completed successfully |
| err | output | 1 | Last run ended in error |
| err_kind | output | 2 | 0 none, 1 init timeout, 2 done timeout |

## Verification
The assertions check on every cycle the properties that hold over the whole run. The program line only goes low with power applied and a quiet clock and data pair. Data stays still while the serial clock is high. No byte is accepted beyond the latched count, and no done-wait pulse is issued beyond the limit. The outcome flags stay mutually consistent. Only the bench scenarios can show the exact settle and program-pulse lengths, the polling window before an init timeout, the MSB-first byte contents, how far a source error truncates the stream, and the number of trailing pulses before done is seen.

// File: rtl/fpga_sercfg_pkg.sv
package fpga_sercfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POWER, ST_PROG, ST_INIT, ST_SHIFT, ST_DWAIT, ST_OK, ST_FAIL
  } cfg_state_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_INIT = 2'd1,
    FK_DONE = 2'd2
  } fail_kind_e;

  // Delay in system cycles for a time given in milliseconds.
  function automatic int unsigned ms_to_cycles(input int unsigned ms,
                                               input int unsigned cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction

  // Bits needed to hold values 0..maxval.
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // Cycles a single serial bit occupies on the wire.
  function automatic int unsigned bit_cycles(input int unsigned half_div);
    return 2 * half_div;
  endfunction

endpackage

// File: rtl/fpga_sercfg_sync.sv
module fpga_sercfg_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/fpga_sercfg_tmr.sv
module fpga_sercfg_tmr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // A load of N-1 keeps the caller in its state for N cycles.
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fpga_sercfg_bitser.sv
module fpga_sercfg_bitser import fpga_sercfg_pkg::*; #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_byte,
  input  logic       ld_pulse,
  input  logic [7:0] byte_in,
  output logic       ser_clk,
  output logic       ser_dat,
  output logic       idle
);
  localparam int unsigned DW = cnt_width(CLK_DIV);
  localparam logic [DW-1:0] RELOAD = DW'(CLK_DIV - 1);

  logic [7:0]    sh_q;
  logic [3:0]    left_q;
  logic          hi_q;
  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      hi_q   <= 1'b0;
      div_q  <= '0;
    end else if (ld_byte) begin
      sh_q   <= byte_in;
      left_q <= 4'd8;
      hi_q   <= 1'b0;
      div_q  <= RELOAD;
    end else if (ld_pulse) begin
      sh_q   <= '0;
      left_q <= 4'd1;
      hi_q   <= 1'b0;
      div_q  <= RELOAD;
    end else if (left_q != 4'd0) begin
      if (div_q != '0) begin
        div_q <= div_q - 1'b1;
      end else if (!hi_q) begin
        hi_q  <= 1'b1;
        div_q <= RELOAD;
      end else begin
        hi_q   <= 1'b0;
        div_q  <= RELOAD;
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) sh_q <= '0;
        else                sh_q <= {sh_q[6:0], 1'b0};
      end
    end
  end

  assign ser_clk = hi_q;
  assign ser_dat = sh_q[7];
  assign idle    = (left_q == 4'd0);
endmodule

// File: rtl/fpga_sercfg.sv
module fpga_sercfg import fpga_sercfg_pkg::*; #(
  parameter int unsigned CYC_PER_MS  = 125000,
  parameter int unsigned SETTLE_MS   = 50,
  parameter int unsigned PROG_MS     = 50,
  parameter int unsigned INIT_TRIES  = 100000,
  parameter int unsigned DONE_PULSES = 100000,
  parameter int unsigned CLK_DIV     = 2,
  parameter int unsigned CNT_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       src_data,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic             src_fail,
  input  logic             tgt_init,
  input  logic             tgt_done,
  output logic             pwr_en,
  output logic             prog_n,
  output logic             cfg_clk,
  output logic             cfg_dat,
  output logic             busy,
  output logic             ok,
  output logic             err,
  output logic [1:0]       err_kind
);
  localparam int unsigned SETTLE_CYC = ms_to_cycles(SETTLE_MS, CYC_PER_MS);
  localparam int unsigned PROG_CYC   = ms_to_cycles(PROG_MS, CYC_PER_MS);
  localparam int unsigned TMR_MAX    = (SETTLE_CYC > PROG_CYC) ? SETTLE_CYC : PROG_CYC;
  localparam int unsigned TMR_W      = cnt_width(TMR_MAX);
  localparam int unsigned TRY_W      = cnt_width(INIT_TRIES);
  localparam int unsigned PUL_W      = cnt_width(DONE_PULSES);

  cfg_state_e       state_q;
  fail_kind_e       kind_q;
  logic [CNT_W-1:0] rem_q;
  logic [TRY_W-1:0] tries_q;
  logic [PUL_W-1:0] pulses_q;
  logic             pwr_q, prog_n_q, busy_q, ok_q, err_q;

  // Synchronised target status lines.
  logic [1:0] tgt_sync;
  logic       init_s, done_s;

  fpga_sercfg_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({tgt_done, tgt_init}),
    .q     (tgt_sync)
  );
  assign init_s = tgt_sync[0];
  assign done_s = tgt_sync[1];

  // Named events shared by the FSM, the serializer and the checker.
  logic ser_idle;
  logic start_ok, init_seen, init_giveup;
  logic byte_take, src_abort, shift_over;
  logic dw_active, dw_check, done_seen, done_giveup, pulse_go;
  logic tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;

  assign start_ok    = start && (state_q == ST_IDLE || state_q == ST_OK || state_q == ST_FAIL);
  assign init_seen   = (state_q == ST_INIT) && init_s;
  assign init_giveup = (state_q == ST_INIT) && !init_s && (tries_q == TRY_W'(INIT_TRIES - 1));
  assign src_ready   = (state_q == ST_SHIFT) && ser_idle && (rem_q != '0) && !src_fail;
  assign byte_take   = src_ready && src_valid;
  assign src_abort   = (state_q == ST_SHIFT) && ser_idle && (rem_q != '0) && src_fail;
  assign shift_over  = (state_q == ST_SHIFT) && ser_idle && (rem_q == '0);
  assign dw_active   = (state_q == ST_DWAIT);
  assign dw_check    = dw_active && ser_idle;
  assign done_seen   = dw_check && done_s;
  assign done_giveup = dw_check && !done_s && (pulses_q == PUL_W'(DONE_PULSES));
  assign pulse_go    = dw_check && !done_s && (pulses_q != PUL_W'(DONE_PULSES));

  assign tmr_load = start_ok || ((state_q == ST_POWER) && tmr_expired);
  assign tmr_val  = start_ok ? TMR_W'(SETTLE_CYC - 1) : TMR_W'(PROG_CYC - 1);

  fpga_sercfg_tmr #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  fpga_sercfg_bitser #(.CLK_DIV(CLK_DIV)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_byte  (byte_take),
    .ld_pulse (pulse_go),
    .byte_in  (src_data),
    .ser_clk  (cfg_clk),
    .ser_dat  (cfg_dat),
    .idle     (ser_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= FK_NONE;
      rem_q    <= '0;
      tries_q  <= '0;
      pulses_q <= '0;
      pwr_q    <= 1'b0;
      prog_n_q <= 1'b1;
      busy_q   <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_OK, ST_FAIL: begin
          if (start_ok) begin
            state_q <= ST_POWER;
            pwr_q   <= 1'b1;
            busy_q  <= 1'b1;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
            kind_q  <= FK_NONE;
            rem_q   <= byte_count;
          end
        end
        ST_POWER: begin
          if (tmr_expired) begin
            state_q  <= ST_PROG;
            prog_n_q <= 1'b0;
          end
        end
        ST_PROG: begin
          if (tmr_expired) begin
            state_q  <= ST_INIT;
            prog_n_q <= 1'b1;
            tries_q  <= '0;
          end
        end
        ST_INIT: begin
          if (init_seen) begin
            state_q <= ST_SHIFT;
          end else if (init_giveup) begin
            state_q <= ST_FAIL;
            err_q   <= 1'b1;
            kind_q  <= FK_INIT;
          end else begin
            tries_q <= tries_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (shift_over || src_abort) begin
            state_q  <= ST_DWAIT;
            pulses_q <= '0;
          end else if (byte_take) begin
            rem_q <= rem_q - 1'b1;
          end
        end
        ST_DWAIT: begin
          if (done_seen) begin
            state_q <= ST_OK;
            busy_q  <= 1'b0;
            ok_q    <= 1'b1;
          end else if (done_giveup) begin
            state_q <= ST_FAIL;
            err_q   <= 1'b1;
            kind_q  <= FK_DONE;
          end else if (pulse_go) begin
            pulses_q <= pulses_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pwr_en   = pwr_q;
  assign prog_n   = prog_n_q;
  assign busy     = busy_q;
  assign ok       = ok_q;
  assign err      = err_q;
  assign err_kind = kind_q;
endmodule

// File: rtl/fpga_sercfg_chk.sv
module fpga_sercfg_chk import fpga_sercfg_pkg::*; #(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned DONE_PULSES = 100000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] byte_count,
  input logic             src_ready,
  input logic             src_fail,
  input logic             pwr_en,
  input logic             prog_n,
  input logic             cfg_clk,
  input logic             cfg_dat,
  input logic             busy,
  input logic             ok,
  input logic             err,
  input logic [1:0]       err_kind,
  input logic             start_ok,
  input logic             byte_take,
  input logic             pulse_go,
  input logic             dw_active
);
  localparam int unsigned PW = cnt_width(DONE_PULSES);

  logic [CNT_W-1:0] lat_cnt, taken;
  logic [PW-1:0]    pul_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      taken    <= '0;
      pul_seen <= '0;
    end else if (start_ok) begin
      lat_cnt  <= byte_count;
      taken    <= '0;
      pul_seen <= '0;
    end else begin
      if (byte_take) taken    <= taken + 1'b1;
      if (pulse_go)  pul_seen <= pul_seen + 1'b1;
    end
  end

  // R2
  start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy && pwr_en && !ok && !err);

  // R3
  prog_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> pwr_en && !cfg_clk && !cfg_dat);

  // R5
  dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> $stable(cfg_dat));

  // R5
  byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> (taken < lat_cnt));

  // R6
  src_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_fail |-> !src_ready);

  // R7
  dwait_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dw_active |-> !cfg_dat);

  // R8
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_go |-> (pul_seen < PW'(DONE_PULSES)));

  // R9
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err) && (!ok || !busy) && (!err || busy));

  // R9
  kind_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_kind != 2'd0));

  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (!busy || err));
endmodule

bind fpga_sercfg fpga_sercfg_chk #(
  .CNT_W       (CNT_W),
  .DONE_PULSES (DONE_PULSES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_count (byte_count),
  .src_ready  (src_ready),
  .src_fail   (src_fail),
  .pwr_en     (pwr_en),
  .prog_n     (prog_n),
  .cfg_clk    (cfg_clk),
  .cfg_dat    (cfg_dat),
  .busy       (busy),
  .ok         (ok),
  .err        (err),
  .err_kind   (err_kind),
  .start_ok   (start_ok),
  .byte_take  (byte_take),
  .pulse_go   (pulse_go),
  .dw_active  (dw_active)
);

// File: tb/fpga_sercfg_bench.sv
`timescale 1ns/1ps
module fpga_sercfg_bench;
  localparam int CPM   = 20;
  localparam int SETMS = 3;
  localparam int PRGMS = 2;
  localparam int TRIES = 50;
  localparam int DPUL  = 30;
  localparam int CDIV  = 2;
  localparam int CW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] src_data = '0;
  logic src_valid = 1'b0, src_fail = 1'b0;
  logic tgt_init = 1'b0, tgt_done = 1'b0;
  logic src_ready, pwr_en, prog_n, cfg_clk, cfg_dat, busy, ok, err;
  logic [1:0] err_kind;

  always #4 clk = ~clk;

  fpga_sercfg #(
    .CYC_PER_MS(CPM), .SETTLE_MS(SETMS), .PROG_MS(PRGMS), .INIT_TRIES(TRIES),
    .DONE_PULSES(DPUL), .CLK_DIV(CDIV), .CNT_W(CW)
  ) u_fpga_sercfg (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .src_fail(src_fail), .tgt_init(tgt_init), .tgt_done(tgt_done),
    .pwr_en(pwr_en), .prog_n(prog_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat),
    .busy(busy), .ok(ok), .err(err), .err_kind(err_kind)
  );

  int checks = 0, fails = 0;

  // Monitor and stimulus state
  logic [7:0] src [0:7];
  logic [7:0] cap [0:63];
  int capn, bitn, rises, hi_run, hi_min, hi_max, prog_lo, settle, post_prog;
  int idx, src_n, err_at, done_mode, done_k, nb_exp;
  bit feed_en, take_pend, prev_clk, seen_lo;
  logic [7:0] bitacc;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // Negedge monitor, byte feeder and done driver in one ordered process.
  initial begin
    prev_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (cfg_clk && !prev_clk) begin
        rises++;
        bitacc = {bitacc[6:0], cfg_dat};
        bitn++;
        if (bitn == 8) begin
          if (capn < 64) cap[capn] = bitacc;
          capn++;
          bitn = 0;
        end
      end
      if (cfg_clk) hi_run++;
      else if (prev_clk) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      prev_clk = cfg_clk;
      if (!prog_n) prog_lo++;
      if (busy && !ok && !err && prog_n && !seen_lo) settle++;
      if (busy && !err && prog_n && seen_lo) post_prog++;
      if (!prog_n) seen_lo = 1'b1;
      if (take_pend) idx++;
      if (feed_en && err_at >= 0 && idx >= err_at) begin
        src_fail  = 1'b1;
        src_valid = 1'b0;
      end else begin
        src_fail  = 1'b0;
        src_valid = feed_en && (idx < src_n);
        if (idx < 8) src_data = src[idx];
      end
      take_pend = src_valid && src_ready;
      case (done_mode)
        0: tgt_done = 1'b0;
        1: tgt_done = 1'b1;
        default: tgt_done = (rises >= 8 * nb_exp + done_k);
      endcase
    end
  end

  task automatic mon_clear();
    capn = 0; bitn = 0; rises = 0; hi_run = 0; hi_min = 1000; hi_max = 0;
    prog_lo = 0; settle = 0; post_prog = 0; idx = 0; take_pend = 1'b0;
    seen_lo = 1'b0; bitacc = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int n;
    n = 0;
    while (!(ok || err) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " run ended"}, int'(ok || err), 1);
  endtask

  task automatic run_cfg(input int nb, input int init_dly, input int dmode,
                         input int dk, input int eat, input int nbx, input bit poke);
    int g;
    mon_clear();
    byte_count = CW'(nb); src_n = nb; err_at = eat; nb_exp = nbx;
    done_mode = dmode; done_k = dk; feed_en = 1'b1; tgt_init = 1'b0;
    pulse_start();
    if (init_dly >= 0) begin
      g = 0;
      while (prog_n && g < 2000) begin @(negedge clk); g++; end
      while (!prog_n && g < 4000) begin @(negedge clk); g++; end
      repeat (init_dly) @(negedge clk);
      tgt_init = 1'b1;
    end
    if (poke) begin
      g = 0;
      while (capn < 1 && g < 2000) begin @(negedge clk); g++; end
      pulse_start();
    end
    wait_end("run");
    feed_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pwr_en", int'(pwr_en), 0);
    chk("R1 prog_n", int'(prog_n), 1);
    chk("R1 clk/dat", int'({cfg_clk, cfg_dat}), 0);
    chk("R1 src_ready", int'(src_ready), 0);
    chk("R1 flags", int'({busy, ok, err, err_kind}), 0);
  endtask

  task automatic t_normal();
    src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'h81;
    run_cfg(3, 3, 2, 2, -1, 3, 1'b1);
    chk("R2 settle cycles", settle, SETMS * CPM);
    chk("R3 program low cycles (R10 no repeat)", prog_lo, PRGMS * CPM);
    chk("R5 byte0", int'(cap[0]), 'hA5);
    chk("R5 byte1", int'(cap[1]), 'h3C);
    chk("R5 byte2 (R10 stream intact)", int'(cap[2]), 'h81);
    chk("R5 bytes taken", idx, 3);
    chk("R5 clk high min", hi_min, CDIV);
    chk("R5 clk high max", hi_max, CDIV);
    chk_rng("R7 trailing pulses", rises - 24, 2, 3);
    chk("R9 ok busy err", int'({ok, busy, err}), 3'b100);
    chk("R9 err_kind", int'(err_kind), 0);
  endtask

  task automatic t_init_timeout();
    src[0] = 8'hFF;
    run_cfg(1, -1, 1, 0, -1, 0, 1'b0);
    chk("R4 err_kind", int'(err_kind), 1);
    chk("R4 polls before fail", post_prog, TRIES);
    chk("R4 no clock", rises, 0);
    chk("R9 err with busy", int'({ok, busy, err}), 3'b011);
  endtask

  task automatic t_done_timeout();
    src[0] = 8'h5A;
    run_cfg(1, 0, 0, 0, -1, 1, 1'b0);
    chk("R8 byte sent", int'(cap[0]), 'h5A);
    chk("R8 pulse count", rises - 8, DPUL);
    chk("R8 err_kind", int'(err_kind), 2);
    chk("R9 err with busy", int'({ok, busy, err}), 3'b011);
  endtask

  task automatic t_abort_restart();
    src[0] = 8'h12; src[1] = 8'hE7; src[2] = 8'h99; src[3] = 8'h44; src[4] = 8'h01;
    mon_clear();
    byte_count = CW'(5); src_n = 5; err_at = 2; nb_exp = 2;
    done_mode = 1; done_k = 0; feed_en = 1'b1; tgt_init = 1'b0;
    pulse_start();
    chk("R11 cleared after restart", int'({busy, ok, err, err_kind}), 5'b10000);
    begin
      int g;
      g = 0;
      while (prog_n && g < 2000) begin @(negedge clk); g++; end
      while (!prog_n && g < 4000) begin @(negedge clk); g++; end
      tgt_init = 1'b1;
    end
    wait_end("abort");
    feed_en = 1'b0;
    chk("R6 bytes taken", idx, 2);
    chk("R6 byte1", int'(cap[1]), 'hE7);
    chk("R7 no trailing pulse when done high", rises, 16);
    chk("R9 ok", int'({ok, busy, err}), 3'b100);
  endtask

  task automatic t_zero_bytes();
    run_cfg(0, 1, 2, 3, -1, 0, 1'b0);
    chk("R5 zero count takes none", idx, 0);
    chk_rng("R7 pulses with zero bytes", rises, 3, 4);
    chk("R9 ok", int'(ok), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    feed_en = 1'b0; done_mode = 0; done_k = 0; err_at = -1; src_n = 0; nb_exp = 0;
    for (int i = 0; i < 8; i++) src[i] = '0;
    mon_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_init_timeout();
    t_done_timeout();
    t_abort_restart();
    t_zero_bytes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule